// File: doc/BRIEF.md
# Multi-Channel Phase-Offset Clock Divider

The block divides its input clock by a programmable period and produces four derived clocks from one shared period counter. All four run at the same frequency. Each channel has its own offset register, which shifts the channel's waveform by a whole number of input-clock cycles. With a period of 100, a 120 MHz input gives 1.2 MHz on every channel. Channel 0 with offset 0 gives a reference clock. Channel 1 with offset 25 gives a copy that lags the reference by 25 input cycles.

Generation can also be held off by a companion pattern generator. When that unit is set to a serial mode rather than direct pin drive, the block stops and waits until a start strobe reports that the shift or rotate has begun. Every setting arrives through a small register write port.

The register map has seven locations:

| Address | Name | Contents |
|---|---|---|
| 0 | period | The divide ratio. A write restarts the counter. |
| 1 | control | Bit 0 is the enable. Bit 1 selects serial mode (0 means direct drive). |
| 2 | start | Any write raises the start flag. |
| 4 to 7 | offset | The offset of channel 0 to channel 3. |

Top module: `offset_clkgen`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, every `clk_out` bit is 0, the counter is 0 and the period is 0.
- R2: For a period P of 2 or more, the shared counter steps 0, 1, …, P−1 and wraps to 0, so every channel repeats with a period of exactly P input cycles.
- R3: A channel with effective offset O is high in the cycle after the counter holds a value c exactly when (c − O) mod P < floor(P/2). It is therefore high for floor(P/2) of every P cycles, including for odd P.
- R4: A channel rises one cycle after the counter equals its effective offset. With P = 100, channel 1 at offset 25 rises 25 cycles after channel 0 at offset 0.
- R5: An offset value greater than or equal to P behaves as offset mod P.
- R6: A write to address 0 loads the new period, restarts the counter at 0 at once and makes all pending offsets active at the same edge.
- R7: A write to an offset register (address 4 + channel) has no effect on the outputs until the counter next wraps from P−1 to 0, or until the next period write.
- R8: A period of 0 or 1 disables generation: all outputs are low and the counter stays at 0.
- R9: While control bit 0 (enable) is 0, the counter holds its value and all outputs are low.
- R10: When control bit 1 is 1 (serial mode), generation halts with the counter frozen and the outputs low. A write to address 2 resumes it from the held count. Any write to address 1 clears that start flag.
- R11: Outputs are registered. A channel reflects the counter value of the previous cycle. After a period write from a disabled state, a channel at offset 0 is low for one sample and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| clk_out | output | 4 | Derived clocks, one bit per channel |

## Verification
The main pattern is a period of 100 with offsets 0, 25, 50 and 75. The bench measures the rise-to-rise distance, the high time and the lag between channels 0 and 1, which separates a wrong terminal count from a wrong phase comparison. A period of 10 with an offset of 25 exposes a missing modulo reduction. A period of 7 separates floor from ceiling in the half-period threshold. An offset write in mid-period shows whether the new value is applied early or waits for the wrap. Disable, serial-mode halt with a later start, period 1 and a mid-run period write each show whether the counter freezes, resumes from the held count or restarts. A behavioural model is compared on every cycle throughout.

// File: rtl/oclk_pkg.sv
package oclk_pkg;
  localparam int ADDR_PERIOD   = 0;
  localparam int ADDR_CTRL     = 1;
  localparam int ADDR_START    = 2;
  localparam int ADDR_OFF_BASE = 4;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SER_BIT  = 1;
endpackage

// File: rtl/oclk_cfg.sv
module oclk_cfg
  import oclk_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  output logic                    en,
  output logic                    ser_mode,
  output logic                    started,
  output logic                    per_we,
  output logic [NCH-1:0][CW-1:0]  off_pend
);
  logic ctrl_we, start_we;

  assign per_we   = we && (addr == AW'(ADDR_PERIOD));
  assign ctrl_we  = we && (addr == AW'(ADDR_CTRL));
  assign start_we = we && (addr == AW'(ADDR_START));

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      ser_mode <= 1'b0;
      started  <= 1'b0;
    end else if (ctrl_we) begin
      en       <= wdata[CTRL_EN_BIT];
      ser_mode <= wdata[CTRL_SER_BIT];
      started  <= 1'b0;
    end else if (start_we) begin
      started  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_off
    logic off_we;
    assign off_we = we && (addr == AW'(ADDR_OFF_BASE + i));
    always_ff @(posedge clk) begin
      if (rst)         off_pend[i] <= '0;
      else if (off_we) off_pend[i] <= wdata;
    end
  end
endmodule

// File: rtl/oclk_counter.sv
module oclk_counter #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    per_we,
  input  logic [CW-1:0]           per_wdata,
  input  logic                    run,
  input  logic [NCH-1:0][CW-1:0]  off_pend,
  output logic [CW-1:0]           cnt,
  output logic [CW-1:0]           per_act,
  output logic [NCH-1:0][CW-1:0]  off_act
);
  logic at_top;
  assign at_top = (cnt == per_act - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_act <= '0;
      off_act <= '0;
    end else if (per_we) begin
      per_act <= per_wdata;
      cnt     <= '0;
      off_act <= off_pend;
    end else if (run) begin
      if (at_top) begin
        cnt     <= '0;
        off_act <= off_pend;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/oclk_chan.sv
module oclk_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] off,
  output logic          out_q
);
  logic [CW-1:0] div_safe, off_eff;
  logic [CW:0]   lag, half;
  logic          hi;

  always_comb begin
    div_safe = (per < CW'(2)) ? CW'(1) : per;
    off_eff  = off % div_safe;
    if (cnt >= off_eff) lag = {1'b0, cnt} - {1'b0, off_eff};
    else                lag = {1'b0, cnt} + {1'b0, per} - {1'b0, off_eff};
    half = {2'b00, per[CW-1:1]};
    hi   = run && (lag < half);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= hi;
  end
endmodule

// File: rtl/offset_clkgen.sv
module offset_clkgen #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  output logic [NCH-1:0] clk_out
);
  logic                   en, ser_mode, started, per_we, run;
  logic [NCH-1:0][CW-1:0] off_pend, off_act;
  logic [CW-1:0]          cnt, per_act;

  oclk_cfg #(.NCH(NCH), .CW(CW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .ser_mode(ser_mode), .started(started), .per_we(per_we),
    .off_pend(off_pend)
  );

  assign run = en && !(ser_mode && !started) && (per_act >= CW'(2));

  oclk_counter #(.NCH(NCH), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .per_we(per_we), .per_wdata(cfg_wdata), .run(run),
    .off_pend(off_pend), .cnt(cnt), .per_act(per_act), .off_act(off_act)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oclk_chan #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .run(run), .cnt(cnt), .per(per_act),
      .off(off_act[i]), .out_q(clk_out[i])
    );
  end
endmodule

// File: rtl/offset_clkgen_chk.sv
module offset_clkgen_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic                   per_we,
  input logic [CW-1:0]          cnt,
  input logic [CW-1:0]          per_act,
  input logic [NCH-1:0][CW-1:0] off_act,
  input logic [NCH-1:0]         clk_out
);
  p_reset_low_r1: assert property (@(posedge clk) rst |=> (clk_out == '0) && (cnt == '0));

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    (per_act >= CW'(2)) |-> (cnt < per_act));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !per_we && (cnt == per_act - CW'(1))) |=> (cnt == '0));

  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    per_we |=> (cnt == '0));

  p_offset_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!per_we && !(run && (cnt == per_act - CW'(1)))) |=> $stable(off_act));

  p_small_period_r8: assert property (@(posedge clk) disable iff (rst)
    (per_act < CW'(2)) |=> (clk_out == '0));

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && !per_we) |=> $stable(cnt));

  p_halt_low_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (clk_out == '0));
endmodule

bind offset_clkgen offset_clkgen_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .per_we(per_we), .cnt(cnt),
  .per_act(per_act), .off_act(off_act), .clk_out(clk_out)
);

// File: tb/tb_offset_clkgen.sv
module tb_offset_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  clk_out;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit model_live = 1'b0;

  offset_clkgen dut (.clk(clk), .rst(rst), .cfg_we(we), .cfg_addr(addr),
                     .cfg_wdata(wdata), .clk_out(clk_out));

  always #4 clk = ~clk;

  // behavioural reference
  int m_per, m_cnt, m_pend[4], m_act[4];
  bit m_en, m_ser, m_started;
  logic [3:0] m_out;

  function automatic bit wave_hi(int c, int off, int p);
    int o, d;
    if (p < 2) return 1'b0;
    o = off % p;
    d = (c - o + p) % p;
    return d < (p / 2);
  endfunction

  always @(posedge clk) begin
    bit live;
    model_live = 1'b1;
    if (rst) begin
      m_per = 0; m_cnt = 0; m_en = 0; m_ser = 0; m_started = 0; m_out = '0;
      for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    end else begin
      live = m_en && !(m_ser && !m_started) && (m_per >= 2);
      for (int i = 0; i < 4; i++) m_out[i] = live && wave_hi(m_cnt, m_act[i], m_per);
      if (we && addr == 3'd0) begin
        m_per = int'(wdata); m_cnt = 0;
        for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
      end else if (live) begin
        if (m_cnt == m_per - 1) begin
          m_cnt = 0;
          for (int i = 0; i < 4; i++) m_act[i] = m_pend[i];
        end else m_cnt++;
      end
      if (we) begin
        if (addr == 3'd1) begin m_en = wdata[0]; m_ser = wdata[1]; m_started = 0; end
        else if (addr == 3'd2) m_started = 1;
        else if (addr >= 3'd4) m_pend[addr - 3'd4] = int'(wdata);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (model_live) begin
      checks++;
      if (clk_out !== m_out) begin
        errors++;
        $display("FAIL %s model compare: actual %b expected %b", cur_req, clk_out, m_out);
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic all_low(int n, string req);
    repeat (n) begin
      @(negedge clk);
      chk(clk_out == 4'b0, req, int'(clk_out), 0);
    end
  endtask

  initial begin
    int r0a, r0b, r1, hi_cnt;
    bit p0, p1;
    repeat (5) @(negedge clk);
    chk(clk_out == 4'b0, "R1", int'(clk_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(clk_out == 4'b0, "R1", int'(clk_out), 0);

    cur_req = "R8";
    wr(1, 1);
    wr(4, 0); wr(5, 25); wr(6, 50); wr(7, 75);
    all_low(10, "R8");

    // R11 + R5: period 10, offset 25 behaves as 5
    cur_req = "R11";
    wr(0, 10);
    chk(clk_out[0] == 1'b0, "R11", int'(clk_out[0]), 0);
    @(negedge clk);
    chk(clk_out[0] == 1'b1, "R11", int'(clk_out[0]), 1);
    cur_req = "R5";
    idle(5);
    chk(clk_out[1] == 1'b1, "R5", int'(clk_out[1]), 1);
    idle(25);

    // R2 R3 R4: period 100
    cur_req = "R4";
    wr(0, 100);
    r0a = -1; r0b = -1; r1 = -1; hi_cnt = 0;
    p0 = clk_out[0]; p1 = clk_out[1];
    for (int k = 0; k < 250; k++) begin
      @(negedge clk);
      if (clk_out[0] && !p0) begin
        if (r0a < 0) r0a = k; else if (r0b < 0) r0b = k;
      end
      if (clk_out[1] && !p1 && r0a >= 0 && r1 < 0) r1 = k;
      if (r0a >= 0 && r0b < 0 && clk_out[0]) hi_cnt++;
      p0 = clk_out[0]; p1 = clk_out[1];
    end
    chk(r0b - r0a == 100, "R2", r0b - r0a, 100);
    chk(hi_cnt == 50, "R3", hi_cnt, 50);
    chk(r1 - r0a == 25, "R4", r1 - r0a, 25);

    cur_req = "R7";
    wr(6, 130);
    idle(220);

    cur_req = "R3";
    wr(0, 7);
    idle(40);

    cur_req = "R8";
    wr(0, 1);
    all_low(20, "R8");

    cur_req = "R9";
    wr(0, 20);
    idle(13);
    wr(1, 0);
    all_low(30, "R9");
    wr(1, 1);
    idle(30);

    cur_req = "R10";
    wr(1, 3);
    all_low(30, "R10");
    wr(2, 1);
    idle(3);
    chk(clk_out != 4'b0, "R10", int'(clk_out), 1);
    idle(50);

    cur_req = "R6";
    idle(7);
    wr(0, 40);
    idle(100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected 0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule